// File: doc/BRIEF.md
# Prefix-Nibble Byte Instruction Decoder

This block turns a stream of fetched 32-bit words into decoded instructions for a byte-coded stack machine. Every word carries four one-byte instructions. Each byte splits into a 4-bit function code in its upper half and a 4-bit data nibble in its lower half. The data nibble is merged into an operand register.

Three function codes never issue on their own. Two of them are prefixes. They extend the operand register one nibble at a time, so a constant or an address of any width is built from a chain of bytes. The third is the operate code, which issues the accumulated operand as an extended opcode instead of as data. Every other code issues at once as a direct instruction. A byte with no prefix in front of it therefore carries a small operand in the range 0 to 15, for example a local slot index or a short constant.

The fetch side offers one word at a time with a valid/ready pair. The execute side sees a one-cycle valid strobe with the function code, an operate flag and the full operand.

Top module: `nib_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `ins_valid` is low, `word_ready` is high and the operand register is zero. The first direct instruction after reset therefore carries only its own nibble.
- R2: Byte k of an accepted word occupies bits [8k+7:8k]. Bytes are consumed least-significant first, one per cycle. Within a byte, bits [7:4] are the function code and bits [3:0] are the data nibble.
- R3: `word_ready` is high whenever no word is held, and also in the cycle that consumes the last byte of the held word. It is low while earlier bytes of the held word remain. With a word always offered, acceptances are exactly 4 cycles apart.
- R4: A byte whose function code is not 0x2, 0x6 or 0xF is a direct instruction. It raises `ins_valid` for one cycle, starting at the clock edge that ends the cycle in which the byte is consumed. The outputs are then `ins_is_op` = 0, `ins_func` = the code, and `ins_operand` = operand register OR nibble.
- R5: Function code 0x2 (prefix) issues nothing. It loads the operand register with (register OR nibble) shifted left by 4.
- R6: Function code 0x6 (negative prefix) issues nothing. It loads the operand register with the bitwise inverse of (register OR nibble), shifted left by 4.
- R7: Function code 0xF (operate) issues with `ins_is_op` = 1, `ins_func` = 0xF, and `ins_operand` = operand register OR nibble, which is the extended opcode.
- R8: After any byte that issues (direct or operate), the operand register is zero.
- R9: Cycles without a byte to consume leave the operand register unchanged. A prefix chain therefore continues across word boundaries and idle gaps.
- R10: Operand bits shifted above bit OPND_W-1 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A fetched word is offered |
| word_data | input | WORD_W | Fetched instruction word, byte 0 in the low bits |
| word_ready | output | 1 | Decoder takes the offered word at this edge |
| ins_valid | output | 1 | One-cycle strobe: a decoded instruction is presented |
| ins_is_op | output | 1 | Instruction is an operate (extended opcode in operand) |
| ins_func | output | 4 | Function code of the issuing byte |
| ins_operand | output | OPND_W | Assembled operand or extended opcode |

## Verification
The bench builds the decoder with WORD_W = 32 and OPND_W = 16. The narrow operand lets a single word of four prefixes push nibbles off the top, so truncation (R10) is reached in a few cycles. It also keeps negative-prefix results easy to read: -1 appears as 0xFFFF. Stimulus covers prefix chains that cross a word boundary after an idle gap, chains of two negative prefixes, operate with and without a prefix, every direct code, and a back-to-back burst that exercises the ready timing.

// File: rtl/nib_dec_pkg.sv
package nib_dec_pkg;

    localparam int unsigned FUNC_W = 4;
    localparam int unsigned NIB_W  = 4;

    localparam logic [FUNC_W-1:0] FN_PFIX = 4'h2;
    localparam logic [FUNC_W-1:0] FN_NFIX = 4'h6;
    localparam logic [FUNC_W-1:0] FN_OPR  = 4'hF;

    typedef enum logic [1:0] {
        CLS_DIRECT,
        CLS_PFIX,
        CLS_NFIX,
        CLS_OPR
    } fn_class_e;

    function automatic fn_class_e classify(input logic [FUNC_W-1:0] f);
        case (f)
            FN_PFIX: classify = CLS_PFIX;
            FN_NFIX: classify = CLS_NFIX;
            FN_OPR:  classify = CLS_OPR;
            default: classify = CLS_DIRECT;
        endcase
    endfunction

endpackage

// File: rtl/nib_unpack.sv
module nib_unpack #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              byte_valid,
    output logic [7:0]        byte_data
);
    localparam int unsigned NBYTES = WORD_W / 8;
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef struct packed {
        logic              full;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } unp_t;

    unp_t s_d, s_q;
    logic last;

    always_comb begin
        last       = (s_q.idx == LAST_IDX);
        word_ready = !s_q.full || last;
        byte_valid = s_q.full;
        byte_data  = s_q.word[s_q.idx*8 +: 8];

        s_d = s_q;
        if (s_q.full) begin
            if (last) s_d.full = 1'b0;
            else      s_d.idx  = s_q.idx + 1'b1;
        end
        if (word_valid && word_ready) begin
            s_d.full = 1'b1;
            s_d.idx  = '0;
            s_d.word = word_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_ready_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.full |-> word_ready);

    assert_step_midword_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !last) |=> (s_q.full && s_q.idx == $past(s_q.idx) + 1'b1));

    assert_load_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> (s_q.full && s_q.idx == '0));

endmodule

// File: rtl/nib_accum.sv
module nib_accum
    import nib_dec_pkg::*;
#(
    parameter int unsigned OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              iss_valid,
    output logic              iss_op,
    output logic [FUNC_W-1:0] iss_func,
    output logic [OPND_W-1:0] iss_operand
);
    typedef struct packed {
        logic [OPND_W-1:0] acc;
    } acc_t;

    acc_t a_d, a_q;
    logic [FUNC_W-1:0] func;
    logic [OPND_W-1:0] merged;
    fn_class_e         cls;

    always_comb begin
        func   = byte_data[7:4];
        cls    = classify(func);
        merged = a_q.acc | OPND_W'(byte_data[NIB_W-1:0]);

        iss_valid   = byte_valid && (cls == CLS_DIRECT || cls == CLS_OPR);
        iss_op      = (cls == CLS_OPR);
        iss_func    = func;
        iss_operand = merged;

        a_d = a_q;
        if (byte_valid) begin
            case (cls)
                CLS_PFIX: a_d.acc = merged << NIB_W;
                CLS_NFIX: a_d.acc = (~merged) << NIB_W;
                default:  a_d.acc = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assert_clear_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (a_q.acc == '0));

    assert_prefix_low_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (cls == CLS_PFIX || cls == CLS_NFIX)) |=> (a_q.acc[NIB_W-1:0] == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(a_q.acc));

endmodule

// File: rtl/nib_decoder.sv
module nib_decoder
    import nib_dec_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              ins_valid,
    output logic              ins_is_op,
    output logic [3:0]        ins_func,
    output logic [OPND_W-1:0] ins_operand
);
    typedef struct packed {
        logic              valid;
        logic              is_op;
        logic [FUNC_W-1:0] func;
        logic [OPND_W-1:0] operand;
    } out_t;

    logic              byte_valid;
    logic [7:0]        byte_data;
    logic              iss_valid;
    logic              iss_op;
    logic [FUNC_W-1:0] iss_func;
    logic [OPND_W-1:0] iss_operand;

    out_t o_d, o_q;

    nib_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    nib_accum #(.OPND_W(OPND_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .iss_valid   (iss_valid),
        .iss_op      (iss_op),
        .iss_func    (iss_func),
        .iss_operand (iss_operand)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = iss_valid;
        if (iss_valid) begin
            o_d.is_op   = iss_op;
            o_d.func    = iss_func;
            o_d.operand = iss_operand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ins_valid   = o_q.valid;
    assign ins_is_op   = o_q.is_op;
    assign ins_func    = o_q.func;
    assign ins_operand = o_q.operand;

    assert_strobe_follows_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> $past(byte_valid));

    assert_op_flag_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_is_op) |-> (ins_func == FN_OPR));

    assert_no_prefix_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (ins_func != FN_PFIX && ins_func != FN_NFIX));

endmodule

// File: tb/nib_decoder_tb.sv
module nib_decoder_tb;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OPND_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_valid = 1'b0;
    logic [WORD_W-1:0] word_data = '0;
    logic              word_ready;
    logic              ins_valid;
    logic              ins_is_op;
    logic [3:0]        ins_func;
    logic [OPND_W-1:0] ins_operand;

    nib_decoder #(.WORD_W(WORD_W), .OPND_W(OPND_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .ins_valid(ins_valid), .ins_is_op(ins_is_op),
        .ins_func(ins_func), .ins_operand(ins_operand)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic              op;
        logic [3:0]        func;
        logic [OPND_W-1:0] opnd;
        int                cyc;
        string             tag;
    } item_t;

    item_t             sbq[$];
    int                checks = 0;
    int                errors = 0;
    int                cyc = 0;
    bit                done = 0;
    logic [OPND_W-1:0] m_acc = '0;
    bit                m_pf = 0;
    bit                m_nf = 0;
    int                prev_acc = -100;

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard monitor: compares every strobe against the model queue (R2 order, R4 timing)
    always @(negedge clk) begin
        if (rst_n && ins_valid && !done) begin
            item_t e;
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected strobe func=%h opnd=%h expected none", ins_func, ins_operand);
            end else begin
                e = sbq.pop_front();
                if (ins_is_op !== e.op || ins_func !== e.func || ins_operand !== e.opnd || cyc != e.cyc) begin
                    errors++;
                    $display("FAIL %s op=%b func=%h opnd=%h cyc=%0d expected op=%b func=%h opnd=%h cyc=%0d",
                             e.tag, ins_is_op, ins_func, ins_operand, cyc, e.op, e.func, e.opnd, e.cyc);
                end
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // Model of the requirements R4..R10, run once the acceptance cycle is known
    task automatic model_word(input logic [WORD_W-1:0] w, input int acc);
        for (int p = 0; p < WORD_W/8; p++) begin
            logic [7:0]        b;
            logic [OPND_W-1:0] cur;
            item_t             it;
            b   = w[p*8 +: 8];
            cur = m_acc | OPND_W'(b[3:0]);
            if (b[7:4] == 4'h2) begin
                m_acc = cur << 4;      // R5, R10 truncation by width
                m_pf  = 1;
            end else if (b[7:4] == 4'h6) begin
                m_acc = (~cur) << 4;   // R6
                m_nf  = 1;
            end else begin
                it.op   = (b[7:4] == 4'hF);
                it.func = b[7:4];
                it.opnd = cur;
                it.cyc  = acc + 1 + p;
                it.tag  = it.op ? "R7" : (m_nf ? "R6" : (m_pf ? "R5" : "R4"));
                sbq.push_back(it);
                m_acc = '0;            // R8
                m_pf  = 0;
                m_nf  = 0;
            end
        end
    endtask

    task automatic send_word(input logic [WORD_W-1:0] w, input bit burst);
        int acc;
        word_valid = 1'b1;
        word_data  = w;
        while (!word_ready) @(negedge clk);
        acc = cyc + 1;
        model_word(w, acc);
        if (burst)
            check(acc - prev_acc == 4,
                  $sformatf("R3 burst spacing actual=%0d expected=4", acc - prev_acc));
        prev_acc = acc;
        @(negedge clk);
        word_valid = 1'b0;
        check(word_ready == 1'b0,
              $sformatf("R3 ready mid-word actual=%b expected=0", word_ready));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] dl[16];
        int         nd;
        @(negedge clk);
        @(negedge clk);
        check(ins_valid == 1'b0, $sformatf("R1 ins_valid in reset actual=%b expected=0", ins_valid));
        check(word_ready == 1'b1, $sformatf("R1 word_ready in reset actual=%b expected=1", word_ready));
        rst_n = 1'b1;
        @(negedge clk);
        check(ins_valid == 1'b0, $sformatf("R1 ins_valid after reset actual=%b expected=0", ins_valid));
        check(word_ready == 1'b1, $sformatf("R1 word_ready after reset actual=%b expected=1", word_ready));

        // R5 R2: constant 0x897 from three bytes, then a direct byte (R1: first issue from zero register)
        send_word(32'h1547_2928, 0);
        idle(6);
        // R6: negative prefix gives all-ones, then plain directs
        send_word(32'h7A3C_4F60, 0);
        idle(6);
        // R7: operate with and without a prefix
        send_word(32'hF03F_F321, 0);
        idle(6);
        // R9 R10: prefix chain overflowing 16 bits, idle gap, finished in next word
        send_word(32'h2C2D_2E2F, 0);
        idle(5);
        send_word(32'h0000_004A, 0);
        idle(6);
        // R6 R8: two negative prefixes then a direct
        send_word(32'h00D2_6165, 0);
        idle(6);
        // R4: every direct code with a single byte
        nd = 0;
        for (int f = 0; f < 16; f++) begin
            if (f != 2 && f != 6 && f != 15) begin
                dl[nd] = {4'(f), 4'(f) ^ 4'h5};
                nd++;
            end
        end
        while (nd < 16) begin
            dl[nd] = 8'h00;
            nd++;
        end
        for (int k = 0; k < 4; k++)
            send_word({dl[4*k+3], dl[4*k+2], dl[4*k+1], dl[4*k]}, 0);
        idle(6);
        // R3: back-to-back burst, acceptances every 4 cycles
        send_word(32'h2122_2324, 0);
        send_word(32'hF1E2_4321, 1);
        send_word(32'h6F5A_2B03, 1);
        send_word(32'h1111_114C, 1);
        idle(8);
        check(sbq.size() == 0, $sformatf("R4 missing strobes actual=%0d expected=0", sbq.size()));
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R4 watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule